// File: doc/BRIEF.md
# Three-Dimensional DMA Address Sequencer

This block is the address engine of a single DMA channel. It holds the channel's active transfer description. From that description it emits a stream of burst commands. Each command carries a source address, a destination address and a byte length. The transfer has three nested dimensions:

- a burst of A bytes, called an array;
- B arrays, which make up a frame;
- C frames, which make up the whole transfer.

Each side has its own signed step between arrays and its own signed step between frames. Either side can instead hold its address fixed at its base.

An event strobe drives the walk. Each event releases the work set by the sync mode. In array mode an event releases one array. In frame mode an event releases all B arrays of the current frame, one command per cycle. After the final array of the last frame, the channel can raise a completion pulse and a chain pulse for a neighbouring channel. It then does one of two things. If linking is enabled, it overwrites its active description with one of its link slots and stays ready. Otherwise it disarms. An event that reaches a disarmed channel produces no command and is reported as a null-transfer error.

Software programs the active description and the link slots one field at a time. A downstream mover consumes the commands. This block performs no memory access.

Top module: `dma3d_seq`

## Requirements
- R1: After reset, cmd_valid, cmd_last, done_irq, chain_trig, null_err and seq_armed are all 0.
- R2: A write targets one parameter set through cfg_tgt: 0 selects the active set, and k selects link slot k-1. It also names a field through cfg_fld:
  - 0: source base
  - 1: destination base
  - 2: A count
  - 3: B count
  - 4: C count
  - 5: source array step
  - 6: destination array step
  - 7: source frame step
  - 8: destination frame step
  - 9: options

  The option bits are:
  - bit 0: frame mode
  - bit 1: hold source address
  - bit 2: hold destination address
  - bit 3: link enable
  - bit 4: chain enable
  - bit 5: completion enable
  - bits 8 and up: link slot

  Writing the options field of the active set arms the channel (seq_armed is 1 from the next cycle). Any write to the active set restarts the walk at array 0 of frame 0.
- R3: In array mode, an event sampled at a clock edge while armed produces exactly one command, registered at that same edge. Its cmd_len equals the A count.
- R4: In frame mode, one event produces B commands on B consecutive edges, starting at the event's edge. Events that arrive while a frame is being emitted are ignored.
- R5: For array b of frame c, the source address is base + b × array step + c × frame step. The steps are 16-bit two's complement values, and the address wraps modulo 2^AW. When the hold-source option is set, every command carries the source base instead.
- R6: The destination address follows the same rule using its own base, steps and hold option, independently of the source side.
- R7: cmd_last is 1 only on the final command of the transfer (b = B-1, c = C-1). done_irq is 1 in that same cycle exactly when the completion option is set.
- R8: chain_trig is 1 in the final command's cycle exactly when the chain option is set, and it is 0 on every other cycle.
- R9: When the link option is set, completion replaces the active set with the selected slot. The channel stays armed, and the next event starts array 0 of frame 0 of the new set. A slot may link to itself for repeated reload.
- R10: When the link option is clear, completion disarms the channel. An event at a disarmed channel gives null_err = 1 one edge later and no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Field write strobe |
| cfg_tgt | input | TW | Target set: 0 active, k slot k-1 |
| cfg_fld | input | 4 | Field code |
| cfg_data | input | 32 | Write data |
| ev | input | 1 | Synchronization event |
| cmd_valid | output | 1 | Burst command present |
| cmd_src | output | AW | Source address of the burst |
| cmd_dst | output | AW | Destination address of the burst |
| cmd_len | output | CNTW | Burst length in bytes |
| cmd_last | output | 1 | Final burst of the transfer |
| done_irq | output | 1 | Completion pulse |
| chain_trig | output | 1 | Trigger for a chained channel |
| null_err | output | 1 | Event arrived with nothing to transfer |
| seq_armed | output | 1 | Channel holds a live transfer |

## Verification
The bench sweeps both sync modes over every combination of B from 1 to 3 and C from 1 to 2, with negative and positive steps and each hold option. Each sweep point checks the full address sequence against the arithmetic formula. The sweep catches several classes of fault:
- A design that confuses the frame step with the array step, or that forgets to return to the frame start, emits wrong addresses from the second frame on.
- A design that mishandles sign extension is wrong on the negative-step cases.
- The B = 1 and C = 1 points expose off-by-one errors in detecting the last array, which would show up as a missing or extra command or a misplaced cmd_last.

In frame mode a second event is raised mid-frame; a design that did not ignore it would start an extra frame. The link cases look for a stale position after reload or a wrong disarm. A channel that disarmed on a linked completion would raise null_err instead of emitting the reloaded set. A channel that failed to disarm would emit commands after the final one.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;

   // Field selector codes for the programming port.
   typedef enum logic [3:0] {
      FLD_SRC_BASE  = 4'd0,
      FLD_DST_BASE  = 4'd1,
      FLD_ACNT      = 4'd2,
      FLD_BCNT      = 4'd3,
      FLD_CCNT      = 4'd4,
      FLD_SRC_BSTEP = 4'd5,
      FLD_DST_BSTEP = 4'd6,
      FLD_SRC_CSTEP = 4'd7,
      FLD_DST_CSTEP = 4'd8,
      FLD_OPTS      = 4'd9
   } fld_e;

   // Option flag positions; the same positions are used in cfg_data and in
   // the compact stored option vector (slot field is packed above the flags).
   localparam int OPT_AB        = 0;
   localparam int OPT_SRC_HOLD  = 1;
   localparam int OPT_DST_HOLD  = 2;
   localparam int OPT_LINK      = 3;
   localparam int OPT_CHAIN     = 4;
   localparam int OPT_DONE      = 5;
   localparam int OPT_NFLAG     = 6;
   localparam int OPT_SLOT_LSB  = 8;

endpackage

// File: rtl/dma3d_pset_store.sv
module dma3d_pset_store
   import dma3d_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CNTW  = 16,
   parameter int IDXW  = 16,
   parameter int NSLOT = 2,
   parameter int SLW   = 1,
   parameter int TW    = 2,
   parameter int OPTW  = OPT_NFLAG + SLW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_wr,
   input  logic [TW-1:0]   cfg_tgt,
   input  logic [3:0]      cfg_fld,
   input  logic [31:0]     cfg_data,
   input  logic            reload,
   input  logic [SLW-1:0]  reload_slot,
   output logic [AW-1:0]   act_src_base,
   output logic [AW-1:0]   act_dst_base,
   output logic [CNTW-1:0] act_acnt,
   output logic [CNTW-1:0] act_bcnt,
   output logic [CNTW-1:0] act_ccnt,
   output logic [IDXW-1:0] act_src_bstep,
   output logic [IDXW-1:0] act_dst_bstep,
   output logic [IDXW-1:0] act_src_cstep,
   output logic [IDXW-1:0] act_dst_cstep,
   output logic [OPTW-1:0] act_opt
);

   // Packed layout of one parameter set, LSB upward.
   localparam int L_OPT = 0;
   localparam int L_DCS = L_OPT + OPTW;
   localparam int L_SCS = L_DCS + IDXW;
   localparam int L_DBS = L_SCS + IDXW;
   localparam int L_SBS = L_DBS + IDXW;
   localparam int L_CC  = L_SBS + IDXW;
   localparam int L_BC  = L_CC + CNTW;
   localparam int L_AC  = L_BC + CNTW;
   localparam int L_DB  = L_AC + CNTW;
   localparam int L_SB  = L_DB + AW;
   localparam int SETW  = L_SB + AW;

   function automatic logic [SETW-1:0] apply_wr(
      input logic [SETW-1:0] s,
      input logic [3:0]      f,
      input logic [31:0]     d
   );
      logic [SETW-1:0] r;
      r = s;
      case (f)
         FLD_SRC_BASE:  r[L_SB  +: AW]   = d[AW-1:0];
         FLD_DST_BASE:  r[L_DB  +: AW]   = d[AW-1:0];
         FLD_ACNT:      r[L_AC  +: CNTW] = d[CNTW-1:0];
         FLD_BCNT:      r[L_BC  +: CNTW] = d[CNTW-1:0];
         FLD_CCNT:      r[L_CC  +: CNTW] = d[CNTW-1:0];
         FLD_SRC_BSTEP: r[L_SBS +: IDXW] = d[IDXW-1:0];
         FLD_DST_BSTEP: r[L_DBS +: IDXW] = d[IDXW-1:0];
         FLD_SRC_CSTEP: r[L_SCS +: IDXW] = d[IDXW-1:0];
         FLD_DST_CSTEP: r[L_DCS +: IDXW] = d[IDXW-1:0];
         FLD_OPTS:      r[L_OPT +: OPTW] = {d[OPT_SLOT_LSB +: SLW], d[OPT_NFLAG-1:0]};
         default:       r = s;
      endcase
      return r;
   endfunction

   logic [SETW-1:0] slot_v [NSLOT];
   logic [SETW-1:0] act_q;
   logic [SETW-1:0] link_src;

   // One register bank per link slot.
   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      logic [SETW-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (cfg_wr && (cfg_tgt == TW'(g + 1)))
            slot_q <= apply_wr(slot_q, cfg_fld, cfg_data);
      end
      assign slot_v[g] = slot_q;
   end

   always_comb begin
      link_src = slot_v[0];
      for (int i = 1; i < NSLOT; i++)
         if (reload_slot == SLW'(i)) link_src = slot_v[i];
   end

   // Active set: a reload takes precedence over a concurrent field write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         act_q <= '0;
      else if (reload)
         act_q <= link_src;
      else if (cfg_wr && (cfg_tgt == '0))
         act_q <= apply_wr(act_q, cfg_fld, cfg_data);
   end

   assign act_src_base  = act_q[L_SB  +: AW];
   assign act_dst_base  = act_q[L_DB  +: AW];
   assign act_acnt      = act_q[L_AC  +: CNTW];
   assign act_bcnt      = act_q[L_BC  +: CNTW];
   assign act_ccnt      = act_q[L_CC  +: CNTW];
   assign act_src_bstep = act_q[L_SBS +: IDXW];
   assign act_dst_bstep = act_q[L_DBS +: IDXW];
   assign act_src_cstep = act_q[L_SCS +: IDXW];
   assign act_dst_cstep = act_q[L_DCS +: IDXW];
   assign act_opt       = act_q[L_OPT +: OPTW];

endmodule

// File: rtl/dma3d_walker.sv
module dma3d_walker #(
   parameter int CNTW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ev,
   input  logic            sync_ab,
   input  logic [CNTW-1:0] bcnt,
   input  logic [CNTW-1:0] ccnt,
   input  logic            arm,
   input  logic            pos_clr,
   input  logic            link_ok,
   output logic            issue,
   output logic [CNTW-1:0] b_pos,
   output logic [CNTW-1:0] c_pos,
   output logic            lif,
   output logic            last_xfer,
   output logic            armed,
   output logic            null_evt
);

   logic            busy_q;
   logic            armed_q;
   logic [CNTW-1:0] b_q;
   logic [CNTW-1:0] c_q;
   logic            start;

   // A new event is only taken between frames; during a frame walk it is dropped.
   assign start     = ev && armed_q && !busy_q;
   assign issue     = start || busy_q;
   assign lif       = (b_q == bcnt - CNTW'(1));
   assign last_xfer = issue && lif && (c_q == ccnt - CNTW'(1));
   assign null_evt  = ev && !armed_q && !busy_q;
   assign b_pos     = b_q;
   assign c_pos     = c_q;
   assign armed     = armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         b_q    <= '0;
         c_q    <= '0;
      end else if (pos_clr || last_xfer) begin
         busy_q <= 1'b0;
         b_q    <= '0;
         c_q    <= '0;
      end else if (issue) begin
         if (lif) begin
            b_q    <= '0;
            c_q    <= c_q + CNTW'(1);
            busy_q <= 1'b0;
         end else begin
            b_q    <= b_q + CNTW'(1);
            busy_q <= sync_ab;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed_q <= 1'b0;
      else if (arm)
         armed_q <= 1'b1;
      else if (last_xfer && !link_ok)
         armed_q <= 1'b0;
   end

endmodule

// File: rtl/dma3d_addr_gen.sv
module dma3d_addr_gen #(
   parameter int AW      = 32,
   parameter int CNTW    = 16,
   parameter int IDXW    = 16,
   parameter bit USE_MUL = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   base,
   input  logic [IDXW-1:0] bstep,
   input  logic [IDXW-1:0] cstep,
   input  logic            hold,
   input  logic [CNTW-1:0] b_pos,
   input  logic [CNTW-1:0] c_pos,
   input  logic            clr,
   input  logic            adv,
   input  logic            lif,
   output logic [AW-1:0]   addr
);

   logic [AW-1:0] bstep_x;
   logic [AW-1:0] cstep_x;
   logic [AW-1:0] off;

   // Steps are two's complement; widen by sign extension so modular adds work.
   assign bstep_x = {{(AW-IDXW){bstep[IDXW-1]}}, bstep};
   assign cstep_x = {{(AW-IDXW){cstep[IDXW-1]}}, cstep};

   if (USE_MUL) begin : g_mul
      // Offset computed directly from the position counters.
      logic [AW-1:0] b_x;
      logic [AW-1:0] c_x;
      logic          unused_mul;
      assign b_x = AW'(b_pos);
      assign c_x = AW'(c_pos);
      assign off = (b_x * bstep_x) + (c_x * cstep_x);
      assign unused_mul = ^{clk, rst_n, clr, adv, lif};
   end else begin : g_acc
      // Running offsets: array start and frame start, adder only.
      logic [AW-1:0] arr_q;
      logic [AW-1:0] frm_q;
      logic          unused_acc;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            arr_q <= '0;
            frm_q <= '0;
         end else if (clr) begin
            arr_q <= '0;
            frm_q <= '0;
         end else if (adv) begin
            if (lif) begin
               frm_q <= frm_q + cstep_x;
               arr_q <= frm_q + cstep_x;
            end else begin
               arr_q <= arr_q + bstep_x;
            end
         end
      end
      assign off = arr_q;
      assign unused_acc = ^{b_pos, c_pos};
   end

   assign addr = hold ? base : base + off;

endmodule

// File: rtl/dma3d_seq.sv
module dma3d_seq
   import dma3d_pkg::*;
#(
   parameter int  AW      = 32,
   parameter int  CNTW    = 16,
   parameter int  IDXW    = 16,
   parameter int  NSLOT   = 2,
   parameter bit  USE_MUL = 1'b0,
   localparam int SLW     = (NSLOT > 1) ? $clog2(NSLOT) : 1,
   localparam int TW      = $clog2(NSLOT + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_wr,
   input  logic [TW-1:0]   cfg_tgt,
   input  logic [3:0]      cfg_fld,
   input  logic [31:0]     cfg_data,
   input  logic            ev,
   output logic            cmd_valid,
   output logic [AW-1:0]   cmd_src,
   output logic [AW-1:0]   cmd_dst,
   output logic [CNTW-1:0] cmd_len,
   output logic            cmd_last,
   output logic            done_irq,
   output logic            chain_trig,
   output logic            null_err,
   output logic            seq_armed
);

   localparam int OPTW = OPT_NFLAG + SLW;

   if (AW > 32 || AW < IDXW || AW < CNTW) begin : g_bad_aw
      $error("dma3d_seq: AW must be <= 32 and >= IDXW and CNTW");
   end
   if (NSLOT < 1 || OPT_SLOT_LSB + SLW > 32) begin : g_bad_slot
      $error("dma3d_seq: link slot count out of range");
   end

   logic [AW-1:0]   src_base, dst_base, src_addr, dst_addr;
   logic [CNTW-1:0] acnt, bcnt, ccnt, b_pos, c_pos;
   logic [IDXW-1:0] sbs, dbs, scs, dcs;
   logic [OPTW-1:0] opt;
   logic [SLW-1:0]  link_slot;
   logic            act_wr, arm, link_ok, reload, pos_rst;
   logic            issue, lif, last_xfer, armed, null_evt;

   assign act_wr    = cfg_wr && (cfg_tgt == '0);
   assign arm       = act_wr && (cfg_fld == FLD_OPTS);
   assign link_slot = opt[OPT_NFLAG +: SLW];

   if ((1 << SLW) == NSLOT) begin : g_link_full
      assign link_ok = opt[OPT_LINK];
   end else begin : g_link_range
      assign link_ok = opt[OPT_LINK] && (32'(link_slot) < NSLOT);
   end

   assign reload  = last_xfer && link_ok;
   assign pos_rst = act_wr || last_xfer;

   dma3d_pset_store #(
      .AW(AW), .CNTW(CNTW), .IDXW(IDXW), .NSLOT(NSLOT), .SLW(SLW), .TW(TW)
   ) u_store (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_wr        (cfg_wr),
      .cfg_tgt       (cfg_tgt),
      .cfg_fld       (cfg_fld),
      .cfg_data      (cfg_data),
      .reload        (reload),
      .reload_slot   (link_slot),
      .act_src_base  (src_base),
      .act_dst_base  (dst_base),
      .act_acnt      (acnt),
      .act_bcnt      (bcnt),
      .act_ccnt      (ccnt),
      .act_src_bstep (sbs),
      .act_dst_bstep (dbs),
      .act_src_cstep (scs),
      .act_dst_cstep (dcs),
      .act_opt       (opt)
   );

   dma3d_walker #(.CNTW(CNTW)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev),
      .sync_ab   (opt[OPT_AB]),
      .bcnt      (bcnt),
      .ccnt      (ccnt),
      .arm       (arm),
      .pos_clr   (act_wr),
      .link_ok   (link_ok),
      .issue     (issue),
      .b_pos     (b_pos),
      .c_pos     (c_pos),
      .lif       (lif),
      .last_xfer (last_xfer),
      .armed     (armed),
      .null_evt  (null_evt)
   );

   dma3d_addr_gen #(.AW(AW), .CNTW(CNTW), .IDXW(IDXW), .USE_MUL(USE_MUL)) u_src (
      .clk   (clk),
      .rst_n (rst_n),
      .base  (src_base),
      .bstep (sbs),
      .cstep (scs),
      .hold  (opt[OPT_SRC_HOLD]),
      .b_pos (b_pos),
      .c_pos (c_pos),
      .clr   (pos_rst),
      .adv   (issue),
      .lif   (lif),
      .addr  (src_addr)
   );

   dma3d_addr_gen #(.AW(AW), .CNTW(CNTW), .IDXW(IDXW), .USE_MUL(USE_MUL)) u_dst (
      .clk   (clk),
      .rst_n (rst_n),
      .base  (dst_base),
      .bstep (dbs),
      .cstep (dcs),
      .hold  (opt[OPT_DST_HOLD]),
      .b_pos (b_pos),
      .c_pos (c_pos),
      .clr   (pos_rst),
      .adv   (issue),
      .lif   (lif),
      .addr  (dst_addr)
   );

   // Command and status registers.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid  <= 1'b0;
         cmd_src    <= '0;
         cmd_dst    <= '0;
         cmd_len    <= '0;
         cmd_last   <= 1'b0;
         done_irq   <= 1'b0;
         chain_trig <= 1'b0;
         null_err   <= 1'b0;
      end else begin
         cmd_valid  <= issue;
         cmd_last   <= last_xfer;
         done_irq   <= last_xfer && opt[OPT_DONE];
         chain_trig <= last_xfer && opt[OPT_CHAIN];
         null_err   <= null_evt;
         if (issue) begin
            cmd_src <= src_addr;
            cmd_dst <= dst_addr;
            cmd_len <= acnt;
         end
      end
   end

   assign seq_armed = armed;

endmodule

// File: rtl/dma3d_seq_chk.sv
module dma3d_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic ev,
   input logic cmd_valid,
   input logic cmd_last,
   input logic done_irq,
   input logic chain_trig,
   input logic null_err,
   input logic seq_armed
);

   p_cmd_needs_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(seq_armed));

   p_last_is_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_last |-> cmd_valid);

   p_done_on_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |-> (cmd_valid && cmd_last));

   p_chain_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chain_trig |-> (cmd_valid && cmd_last));

   p_null_no_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      null_err |-> !cmd_valid);

   p_null_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      null_err |-> ($past(ev) && !$past(seq_armed)));

   p_disarm_at_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(seq_armed) |-> cmd_last);

endmodule

bind dma3d_seq dma3d_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ev         (ev),
   .cmd_valid  (cmd_valid),
   .cmd_last   (cmd_last),
   .done_irq   (done_irq),
   .chain_trig (chain_trig),
   .null_err   (null_err),
   .seq_armed  (seq_armed)
);

// File: tb/tb_dma3d_seq.sv
`timescale 1ns/1ps
module tb_dma3d_seq;

   localparam int AW = 32, CNTW = 16, TW = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_wr = 1'b0;
   logic [TW-1:0]   cfg_tgt = '0;
   logic [3:0]      cfg_fld = '0;
   logic [31:0]     cfg_data = '0;
   logic            ev = 1'b0;
   logic            cmd_valid, cmd_last, done_irq, chain_trig, null_err, seq_armed;
   logic [AW-1:0]   cmd_src, cmd_dst;
   logic [CNTW-1:0] cmd_len;

   always #2 clk = ~clk;

   dma3d_seq dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_tgt(cfg_tgt), .cfg_fld(cfg_fld),
      .cfg_data(cfg_data), .ev(ev), .cmd_valid(cmd_valid), .cmd_src(cmd_src),
      .cmd_dst(cmd_dst), .cmd_len(cmd_len), .cmd_last(cmd_last), .done_irq(done_irq),
      .chain_trig(chain_trig), .null_err(null_err), .seq_armed(seq_armed)
   );

   int n_chk = 0, n_err = 0;
   bit finished = 0;

   // Expected transfer description.
   logic [31:0] x_sb, x_db;
   int x_ac, x_bc, x_cc, x_sbs, x_dbs, x_scs, x_dcs;
   bit x_ab, x_sh, x_dh, x_link, x_chain, x_done;
   int x_slot;

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int tgt, input int fld, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_tgt = TW'(tgt); cfg_fld = 4'(fld); cfg_data = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic set_x(input logic [31:0] sb, db, input int ac, bc, cc, sbs, dbs, scs, dcs,
                        input bit ab, sh, dh, lnk, chn, dn, input int slot);
      x_sb = sb; x_db = db; x_ac = ac; x_bc = bc; x_cc = cc;
      x_sbs = sbs; x_dbs = dbs; x_scs = scs; x_dcs = dcs;
      x_ab = ab; x_sh = sh; x_dh = dh; x_link = lnk; x_chain = chn; x_done = dn; x_slot = slot;
   endtask

   // R2: field codes 0..9, options written last
   task automatic prog_x(input int tgt);
      logic [31:0] o;
      o = 32'(x_ab) | (32'(x_sh) << 1) | (32'(x_dh) << 2) | (32'(x_link) << 3) |
          (32'(x_chain) << 4) | (32'(x_done) << 5) | (32'(x_slot) << 8);
      wr(tgt, 0, x_sb);            wr(tgt, 1, x_db);
      wr(tgt, 2, 32'(x_ac));       wr(tgt, 3, 32'(x_bc));   wr(tgt, 4, 32'(x_cc));
      wr(tgt, 5, 32'(x_sbs));      wr(tgt, 6, 32'(x_dbs));
      wr(tgt, 7, 32'(x_scs));      wr(tgt, 8, 32'(x_dcs));
      wr(tgt, 9, o);
   endtask

   function automatic logic [31:0] exp_addr(input logic [31:0] base, input int b, c, bs, cs,
                                            input bit hold);
      return hold ? base : base + 32'(b * bs) + 32'(c * cs);
   endfunction

   task automatic check_cmd(input int b, input int c);
      bit last;
      last = (b == x_bc - 1) && (c == x_cc - 1);
      chk(x_ab ? "R4" : "R3", "cmd_valid", 32'(cmd_valid), 32'd1);
      chk("R3", "cmd_len", 32'(cmd_len), 32'(x_ac));
      chk("R5", "cmd_src", cmd_src, exp_addr(x_sb, b, c, x_sbs, x_scs, x_sh));
      chk("R6", "cmd_dst", cmd_dst, exp_addr(x_db, b, c, x_dbs, x_dcs, x_dh));
      chk("R7", "cmd_last", 32'(cmd_last), 32'(last));
      chk("R7", "done_irq", 32'(done_irq), 32'(last && x_done));
      chk("R8", "chain_trig", 32'(chain_trig), 32'(last && x_chain));
   endtask

   task automatic run_xfer(input bit dbl);
      for (int c = 0; c < x_cc; c++) begin
         if (!x_ab) begin
            for (int b = 0; b < x_bc; b++) begin
               @(negedge clk) ev = 1'b1;
               @(negedge clk) ev = 1'b0;
               check_cmd(b, c);
               @(negedge clk);
               chk("R3", "single cmd per event", 32'(cmd_valid), 32'd0);
            end
         end else begin
            @(negedge clk) ev = 1'b1;
            @(negedge clk) ev = dbl && (x_bc > 1);
            check_cmd(0, c);
            for (int b = 1; b < x_bc; b++) begin
               @(negedge clk) ev = 1'b0;
               check_cmd(b, c);
            end
            @(negedge clk);
            chk("R4", "frame ends, mid-frame event ignored", 32'(cmd_valid), 32'd0);
         end
      end
   endtask

   task automatic null_probe();
      @(negedge clk) ev = 1'b1;
      @(negedge clk) ev = 1'b0;
      chk("R10", "null_err", 32'(null_err), 32'd1);
      chk("R10", "no cmd on null", 32'(cmd_valid), 32'd0);
      @(negedge clk);
      chk("R10", "null_err pulse", 32'(null_err), 32'd0);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "cmd_valid", 32'(cmd_valid), 0);
      chk("R1", "cmd_last", 32'(cmd_last), 0);
      chk("R1", "done_irq", 32'(done_irq), 0);
      chk("R1", "chain_trig", 32'(chain_trig), 0);
      chk("R1", "null_err", 32'(null_err), 0);
      chk("R1", "seq_armed", 32'(seq_armed), 0);
      null_probe();

      // Sweep: both modes, B 1..3, C 1..2, two step/hold variants.
      for (int ab = 0; ab < 2; ab++)
         for (int bc = 1; bc <= 3; bc++)
            for (int cc = 1; cc <= 2; cc++)
               for (int v = 0; v < 2; v++) begin
                  set_x(32'h1000_0040 + 32'(bc * 16), 32'h2000_0100 - 32'(cc * 8),
                        4 + bc + cc, bc, cc,
                        v ? -24 : 64, v ? 16 : -8, v ? 256 : -512, v ? -1000 : 300,
                        ab[0], v[0] && bc == 2, !v[0] && cc == 2, 1'b0,
                        bc != 2, v[0] || bc == 1, 0);
                  prog_x(0);
                  chk("R2", "armed after options write", 32'(seq_armed), 32'd1);
                  run_xfer(1'b1);
                  chk("R10", "disarmed at completion", 32'(seq_armed), 32'd0);
                  null_probe();
               end

      // R9: active links to slot 1, which holds an A-sync set.
      set_x(32'h3000_0000, 32'h4000_0000, 8, 2, 2, 4, -4, 100, -100,
            1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0);
      prog_x(2);
      set_x(32'h5000_0000, 32'h6000_0000, 12, 3, 1, -12, 12, 0, 0,
            1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1);
      prog_x(0);
      run_xfer(1'b0);
      chk("R9", "armed after linked completion", 32'(seq_armed), 32'd1);
      set_x(32'h3000_0000, 32'h4000_0000, 8, 2, 2, 4, -4, 100, -100,
            1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0);
      run_xfer(1'b0);
      chk("R9", "disarm after unlinked slot set", 32'(seq_armed), 32'd0);
      null_probe();

      // R9: slot 0 links to itself for repeated reload.
      set_x(32'h0000_0010, 32'hFFFF_FFF0, 2, 2, 2, -32, 32, 7, -7,
            1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 0);
      prog_x(1);
      prog_x(0);
      for (int k = 0; k < 3; k++) begin
         run_xfer(1'b1);
         chk("R9", "self-link stays armed", 32'(seq_armed), 32'd1);
      end

      finished = 1;
      summary();
      $finish;
   end

endmodule